// File: doc/BRIEF.md
# Address-Concatenated Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one history register that every resolved branch feeds, plus a table of two-bit saturating counters. A counter is picked by an index made of a few low instruction-address bits joined to the recent global outcome history. The address bits sit in the upper part of the index, so each address pattern owns its own slice of counters, one per history value. This keeps unrelated branches that see the same history from sharing a counter. For a fixed index width, a parameter moves bits from history to address. Setting the address-bit count to zero gives a predictor indexed by history alone.

The fetch side presents a lookup address. One cycle later the block returns the prediction and the history value it used. The execute side later resolves the branch with its address, that history snapshot and the real outcome. The snapshot picks the counter to train, and the real outcome is shifted into the global history at once.

After reset the block spends one cycle per table entry writing every counter to weakly not-taken. It reports this with `busy` and ignores all traffic until the sweep ends.

Top module: `gcat_predictor`

## Requirements
- R1: After reset, `busy` stays high for exactly 2^IDX_W cycles, then falls and stays low until the next reset. `pred_valid` is low throughout that time.
- R2: When the sweep ends, every counter holds 01 (weakly not-taken), so a first lookup of any entry returns `pred_taken` = 0.
- R3: A lookup accepted at a clock edge (`lkp_valid` high, `busy` low) raises `pred_valid` for exactly the following cycle. `pred_valid` is low in every other cycle.
- R4: The global history resets to 0. Each accepted resolve shifts `res_taken` into bit 0 and drops the oldest bit (bit HIST_W-1). `pred_hist` returns the history value that was in place at the lookup edge.
- R5: The counter index is {pc[PC_LSB+ADDR_BITS-1:PC_LSB], history}, with the address bits in the upper positions. With the defaults this is {pc[7:2], hist[5:0]}. Addresses that differ only outside pc[7:2] share counters. Addresses that differ inside it do not.
- R6: A counter moves up one step on a taken outcome and down one step on a not-taken outcome. It stays at 11 on a taken outcome and at 00 on a not-taken outcome. `pred_taken` is bit 1 of the counter.
- R7: A resolve trains the counter chosen by `res_pc` and `res_hist`, not by the current global history.
- R8: Resolves on consecutive cycles to the same counter each take effect. None is lost.
- R9: A lookup or resolve presented while `busy` is high is ignored. It gives no prediction, does not shift the history and does not train any counter.
- R10: With ADDR_BITS = 0, the index is the history alone, so any two addresses seen under the same history share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pc | input | PC_W | Address of the branch to predict |
| res_valid | input | 1 | Resolve request |
| res_pc | input | PC_W | Address of the resolved branch |
| res_hist | input | HIST_W | History snapshot returned with that branch's prediction |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| busy | output | 1 | Counter initialisation sweep in progress |
| pred_valid | output | 1 | Prediction available this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Global history used for this prediction |

## Verification
The bench pulses a lookup and a taken resolve while the sweep is running. A design that let either through would either show a prediction too early or return a nonzero history snapshot afterwards. It pushes one counter into both saturation limits and steps back out, which catches counters that wrap, and a loss of hysteresis after a single opposite outcome. Three resolves to one counter on back-to-back cycles expose a missing write bypass: with the old counter read twice, a taken-taken-not-taken burst ends as not-taken instead of taken. The bench also trains under one history and looks up under another, moves the address in bits inside and outside the index field, and runs a second instance with no address bits. Together these catch an index built from the live history, a wrong address slice or order, or an address leaking into the history-only form.

// File: rtl/gcat_pkg.sv
package gcat_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    ctr_t n;
    if (taken) n = (c == 2'b11) ? c : c + 2'd1;
    else       n = (c == 2'b00) ? c : c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/gcat_ghist.sv
module gcat_ghist #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/gcat_index.sv
module gcat_index #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int ADDR_BITS = 6,
  parameter int HIST_W    = 6,
  localparam int IDX_W    = ADDR_BITS + HIST_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic unused_pc;
  assign unused_pc = ^pc;

  generate
    if (ADDR_BITS == 0) begin : g_hist_only
      assign idx = hist;
    end else begin : g_concat
      assign idx = {pc[PC_LSB+ADDR_BITS-1:PC_LSB], hist};
    end
  endgenerate
endmodule

// File: rtl/gcat_ctr_ram.sv
module gcat_ctr_ram
  import gcat_pkg::*;
#(
  parameter int AW     = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output ctr_t          ra_data,
  input  logic [AW-1:0] rb_addr,
  output ctr_t          rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  ctr_t          wd
);
  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (ra_en) ra_data <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/gcat_predictor.sv
module gcat_predictor
  import gcat_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_W     = 12,
  parameter int ADDR_BITS = 6,
  localparam int HIST_W   = IDX_W - ADDR_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [PC_W-1:0]   lkp_pc,
  input  logic              res_valid,
  input  logic [PC_W-1:0]   res_pc,
  input  logic [HIST_W-1:0] res_hist,
  input  logic              res_taken,
  output logic              busy,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist
);
  logic              acc_lk, acc_rs;
  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  lk_idx, rs_idx, init_idx;
  ctr_t              lk_ctr, up_raw, up_cur, up_new;
  logic              up_v, up_tk, wl_v;
  logic [IDX_W-1:0]  up_idx, wl_idx;
  ctr_t              wl_val;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_wa;
  ctr_t              ram_wd;

  assign acc_lk = lkp_valid & ~busy;
  assign acc_rs = res_valid & ~busy;

  // initialisation sweep
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      init_idx <= '0;
    end else if (busy) begin
      init_idx <= init_idx + 1'b1;
      if (init_idx == {IDX_W{1'b1}}) busy <= 1'b0;
    end
  end

  gcat_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk(clk), .rst(rst), .shift_en(acc_rs), .bit_in(res_taken), .hist(ghr_q)
  );

  gcat_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ADDR_BITS(ADDR_BITS), .HIST_W(HIST_W)) u_idx_lk (
    .pc(lkp_pc), .hist(ghr_q), .idx(lk_idx)
  );

  gcat_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ADDR_BITS(ADDR_BITS), .HIST_W(HIST_W)) u_idx_rs (
    .pc(res_pc), .hist(res_hist), .idx(rs_idx)
  );

  gcat_ctr_ram #(.AW(IDX_W)) u_ram (
    .clk(clk),
    .ra_en(acc_lk), .ra_addr(lk_idx), .ra_data(lk_ctr),
    .rb_addr(rs_idx), .rb_data(up_raw),
    .we(ram_we), .wa(ram_wa), .wd(ram_wd)
  );

  // prediction side
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= acc_lk;
      if (acc_lk) pred_hist <= ghr_q;
    end
  end
  assign pred_taken = lk_ctr[1];

  // update side: read in the accept cycle, write one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      up_v   <= 1'b0;
      up_tk  <= 1'b0;
      up_idx <= '0;
      wl_v   <= 1'b0;
      wl_idx <= '0;
      wl_val <= CTR_RESET;
    end else begin
      up_v   <= acc_rs;
      up_tk  <= res_taken;
      up_idx <= rs_idx;
      wl_v   <= up_v;
      wl_idx <= up_idx;
      wl_val <= up_new;
    end
  end

  // the previous write is not yet visible to the read port: forward it
  assign up_cur = (wl_v && (wl_idx == up_idx)) ? wl_val : up_raw;
  assign up_new = ctr_step(up_cur, up_tk);

  always_comb begin
    if (busy) begin
      ram_we = 1'b1;
      ram_wa = init_idx;
      ram_wd = CTR_RESET;
    end else begin
      ram_we = up_v;
      ram_wa = up_idx;
      ram_wd = up_new;
    end
  end

  logic unused_pc;
  assign unused_pc = ^{lkp_pc, res_pc};
endmodule

// File: rtl/gcat_chk.sv
module gcat_chk #(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              lkp_valid,
  input logic              res_valid,
  input logic              res_taken,
  input logic              pred_valid,
  input logic [HIST_W-1:0] pred_hist,
  input logic [HIST_W-1:0] ghr_q
);
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  a_r1_no_pred_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pred_valid);

  a_r3_valid_after_lookup: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && !busy) |=> pred_valid);

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(lkp_valid && !busy) |=> !pred_valid);

  a_r4_hist_snapshot: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && !busy) |=> (pred_hist == $past(ghr_q)));

  a_r4_newest_bit: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !busy) |=> (ghr_q[0] == $past(res_taken)));

  a_r9_hist_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ghr_q));
endmodule

bind gcat_predictor gcat_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .lkp_valid(lkp_valid),
  .res_valid(res_valid), .res_taken(res_taken), .pred_valid(pred_valid),
  .pred_hist(pred_hist), .ghr_q(ghr_q)
);

// File: tb/test_gcat_predictor.sv
`timescale 1ns/1ps
module test_gcat_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [5:0]  res_hist = '0;
  logic        res_taken = 1'b0;
  logic        busy, pred_valid, pred_taken;
  logic [5:0]  pred_hist;
  logic        p_busy, p_valid, p_taken;
  logic [3:0]  p_hist;

  int checks = 0;
  int errors = 0;
  int mdl_main [4096];
  int mdl_pure [16];
  logic [5:0] ghr_m = '0;
  logic [3:0] ghr_p = '0;

  always #2 clk = ~clk;

  gcat_predictor i_gcat_predictor (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_hist(res_hist), .res_taken(res_taken),
    .busy(busy), .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist)
  );

  gcat_predictor #(.IDX_W(4), .ADDR_BITS(0)) i_gcat_predictor_pure (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_hist(res_hist[3:0]), .res_taken(res_taken),
    .busy(p_busy), .pred_valid(p_valid), .pred_taken(p_taken), .pred_hist(p_hist)
  );

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int step(input int c, input bit tk);
    if (tk) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // R5 / R10 index rules, written from the requirements
  function automatic int idx_main(input logic [31:0] pc, input logic [5:0] h);
    return int'({pc[7:2], h});
  endfunction

  // one resolve cycle; caller ends a burst with rs_end
  task automatic rs(input logic [31:0] pc, input logic [5:0] h, input bit tk);
    res_valid = 1'b1; res_pc = pc; res_hist = h; res_taken = tk;
    @(negedge clk);
    mdl_main[idx_main(pc, h)] = step(mdl_main[idx_main(pc, h)], tk);
    mdl_pure[int'(h[3:0])]    = step(mdl_pure[int'(h[3:0])], tk);
    ghr_m = {ghr_m[4:0], tk};
    ghr_p = {ghr_p[2:0], tk};
  endtask

  task automatic rs_end();
    res_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic train(input logic [31:0] pc, input logic [5:0] h, input bit tk);
    rs(pc, h, tk);
    rs_end();
  endtask

  // drive six resolves from an unrelated address so the history becomes t
  task automatic force_hist(input logic [5:0] t);
    for (int i = 5; i >= 0; i--) rs(32'h0000_00FC, 6'd0, t[i]);
    rs_end();
  endtask

  task automatic lookup(input logic [31:0] pc, input string req);
    int e_m, e_p;
    logic [5:0] e_h;
    logic [3:0] e_ph;
    e_m  = mdl_main[idx_main(pc, ghr_m)] >> 1;
    e_p  = mdl_pure[int'(ghr_p)] >> 1;
    e_h  = ghr_m;
    e_ph = ghr_p;
    lkp_valid = 1'b1; lkp_pc = pc;
    @(negedge clk);
    lkp_valid = 1'b0;
    check(pred_valid === 1'b1, "R3", "pred_valid after lookup", int'(pred_valid), 1);
    check(pred_taken === e_m[0], req, "pred_taken", int'(pred_taken), e_m);
    check(pred_hist === e_h, "R4", "pred_hist", int'(pred_hist), int'(e_h));
    check(p_taken === e_p[0], "R10", "history-only pred_taken", int'(p_taken), e_p);
    check(p_hist === e_ph, "R10", "history-only pred_hist", int'(p_hist), int'(e_ph));
    @(negedge clk);
    check(pred_valid === 1'b0, "R3", "pred_valid one cycle later", int'(pred_valid), 0);
  endtask

  task automatic t_reset_sweep();
    int n;
    bit saw_pred;
    n = 0; saw_pred = 0;
    check(busy === 1'b1, "R1", "busy at reset", int'(busy), 1);
    check(pred_valid === 1'b0, "R1", "pred_valid at reset", int'(pred_valid), 0);
    while (busy === 1'b1 && n < 5000) begin
      if (pred_valid !== 1'b0) saw_pred = 1;
      if (n == 3) begin
        lkp_valid = 1'b1; lkp_pc = 32'h40;
        res_valid = 1'b1; res_pc = 32'h40; res_hist = 6'd0; res_taken = 1'b1;
      end else begin
        lkp_valid = 1'b0; res_valid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    lkp_valid = 1'b0; res_valid = 1'b0;
    check(n == 4096, "R1", "busy cycles", n, 4096);
    check(!saw_pred, "R9", "prediction during sweep", int'(saw_pred), 0);
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after sweep", int'(busy), 0);
    // R9: the resolve during busy must not have shifted history; R2: fresh counter 01
    lookup(32'h40, "R2");
    check(pred_hist === 6'd0, "R9", "history after ignored resolve", int'(pred_hist), 0);
    check(pred_taken === 1'b0, "R2", "fresh counter weakly not-taken", int'(pred_taken), 0);
  endtask

  task automatic t_history_shift();
    train(32'h200, 6'd1, 1'b1);
    train(32'h200, 6'd1, 1'b0);
    train(32'h200, 6'd1, 1'b1);
    train(32'h200, 6'd1, 1'b1);
    lookup(32'h300, "R4");
    check(pred_hist === ghr_m, "R4", "shifted history", int'(pred_hist), int'(ghr_m));
    force_hist(6'b101101);
    lookup(32'h300, "R4");
    check(pred_hist === 6'b101101, "R4", "history oldest dropped", int'(pred_hist), 45);
  endtask

  task automatic t_saturate();
    logic [31:0] a;
    logic [5:0] t;
    a = 32'h0000_0014; t = 6'b010011;
    for (int i = 0; i < 4; i++) train(a, t, 1'b1);
    force_hist(t); lookup(a, "R6");
    check(pred_taken === 1'b1, "R6", "saturated taken", int'(pred_taken), 1);
    train(a, t, 1'b0);
    force_hist(t); lookup(a, "R6");
    check(pred_taken === 1'b1, "R6", "hysteresis after one not-taken", int'(pred_taken), 1);
    for (int i = 0; i < 4; i++) train(a, t, 1'b0);
    force_hist(t); lookup(a, "R6");
    check(pred_taken === 1'b0, "R6", "saturated not-taken", int'(pred_taken), 0);
    train(a, t, 1'b1);
    force_hist(t); lookup(a, "R6");
    check(pred_taken === 1'b0, "R6", "one taken from floor", int'(pred_taken), 0);
  endtask

  task automatic t_address_field();
    logic [31:0] a;
    logic [5:0] t;
    a = 32'h0000_0028; t = 6'b001110;
    train(a, t, 1'b1);
    train(a, t, 1'b1);
    force_hist(t); lookup(a + 32'h100, "R5");
    check(pred_taken === 1'b1, "R5", "alias above index field", int'(pred_taken), 1);
    force_hist(t); lookup(a | 32'h3, "R5");
    check(pred_taken === 1'b1, "R5", "alias below index field", int'(pred_taken), 1);
    force_hist(t); lookup(a + 32'h4, "R5");
    check(pred_taken === 1'b0, "R5", "separate address slice", int'(pred_taken), 0);
  endtask

  task automatic t_snapshot_index();
    logic [31:0] b;
    b = 32'h0000_0088;
    train(b, 6'b110001, 1'b1);
    train(b, 6'b110001, 1'b1);
    force_hist(6'b100110); lookup(b, "R7");
    check(pred_taken === 1'b0, "R7", "other history untouched", int'(pred_taken), 0);
    force_hist(6'b110001); lookup(b, "R7");
    check(pred_taken === 1'b1, "R7", "trained under snapshot", int'(pred_taken), 1);
  endtask

  task automatic t_back_to_back();
    logic [31:0] c;
    logic [5:0] t;
    c = 32'h0000_00C4; t = 6'b011010;
    rs(c, t, 1'b1);
    rs(c, t, 1'b1);
    rs(c, t, 1'b0);
    rs_end();
    force_hist(t); lookup(c, "R8");
    check(pred_taken === 1'b1, "R8", "burst of three to one counter", int'(pred_taken), 1);
  endtask

  task automatic t_history_only();
    logic [5:0] t;
    t = 6'b000111;
    train(32'h0000_0A00, t, 1'b1);
    train(32'h0000_0A00, t, 1'b1);
    force_hist(t); lookup(32'h0000_0B3C, "R10");
    check(p_taken === 1'b1, "R10", "other address shares counter", int'(p_taken), 1);
    check(pred_taken === 1'b0, "R5", "address-indexed form keeps them apart", int'(pred_taken), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mdl_main[i] = 1;
    for (int i = 0; i < 16; i++) mdl_pure[i] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_sweep();
    t_history_shift();
    t_saturate();
    t_address_field();
    t_snapshot_index();
    t_back_to_back();
    t_history_only();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got 1 expected 0");
    finish_run();
  end
endmodule